// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels. Each channel keeps a low count byte and a high count byte. A per-channel mode code arranges those bytes as a 13-bit counter, a 16-bit counter, or an 8-bit counter that reloads from the high byte. A fourth code, which only channel 0 honours, splits channel 0 into two separate 8-bit counters. A channel advances either on a divided internal clock (one step per `PRESCALE` clock cycles) or on falling edges at its external event pin. A gate option makes counting depend on the channel's gate pin being high. When a channel overflows, it sets a flag. The flag is seen on a port, and software or an interrupt acknowledge clears it.

A host reaches all state through a small byte-wide register port with single-cycle writes and a registered read. Clock generation, the processor and interrupt dispatch sit outside this block.

Top module: `dual_tmr_cnt`

## Requirements
- R1: After synchronous reset, every register reads 0x00, the overflow flags are 0, and neither channel counts.
- R2: Register map: address 0 = mode, 1 = control, 2/3 = channel 0 low/high, 4/5 = channel 1 low/high. A write takes effect at the clock edge where `reg_we` is high. `reg_rdata` shows the addressed register one cycle after the address is applied. Control bits 3:0 and addresses 6 and 7 read 0.
- R3: With its source bit at 0, an enabled channel advances exactly once in every `PRESCALE` (default 12) clock cycles.
- R4: With its source bit at 1, a channel advances once for each 1-to-0 transition of its `ext_evt` pin. A low level held for many cycles counts once, and a rise does not count.
- R5: A channel counts only while its run bit is 1 and either its gate bit is 0 or its `gate_pin` is high. Otherwise its count bytes hold.
- R6: Mode code 0 forms a 13-bit count from the high byte (upper bits) and low bits 4:0. Low bits 7:5 are left untouched. Stepping from 0x1FFF gives 0 and sets the flag.
- R7: Mode code 1 forms a 16-bit count {high, low}. Stepping from 0xFFFF gives 0x0000 and sets the flag.
- R8: Mode code 2 steps the low byte only. Stepping from 0xFF loads the low byte from the high byte, leaves the high byte unchanged, and sets the flag.
- R9: Mode code 3 on channel 0: the low byte is an 8-bit counter under channel 0's run, gate and source controls, and it sets flag 0. The high byte steps on the divided clock while channel 1's run bit is 1, and when it passes 0xFF it sets flag 1.
- R10: Channel 1 given mode code 3 holds its count. While channel 0 is in mode code 3, channel 1 still counts in its own mode, but its overflow no longer sets flag 1.
- R11: Mode register nibble layout per channel: bit 3 gate, bit 2 source, bits 1:0 mode code; channel 0 uses bits 3:0 and channel 1 uses bits 7:4. Control bits: 7 flag 1, 6 run 1, 5 flag 0, 4 run 0. A control write loads the flags from the written data. A `flag_ack` pulse clears its flag. An overflow in the same cycle wins over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| ext_evt | input | 2 | Per-channel external event pins (falling edge counts) |
| gate_pin | input | 2 | Per-channel gate pins |
| flag_ack | input | 2 | Per-channel flag clear pulses |
| ovf_flag | output | 2 | Per-channel overflow flags |

## Verification
A wrong count state appears as a wrong byte on `reg_rdata` on the next read of that channel. A wrong step decision appears as a count that is off by the exact number of missed or extra events once the channel is stopped. A fault in the overflow path appears on `ovf_flag` one cycle after the wrapping step. A wrong reload or a wrong split routing appears as a flag raised on the wrong channel, or as a wrong value in the low byte after the wrap. The bench stops each channel before reading it, so every mismatch shows as an exact difference rather than a timing race.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W   = 8;
  localparam int M13_LO_W = 5;
  localparam int N_CH     = 2;
  localparam int ADDR_W   = 3;

  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext_src;
    tmr_mode_e mode;
  } chan_cfg_t;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LO0  = 3'd2;

  localparam int CTL_RUN_BASE  = 4;
  localparam int CTL_FLAG_BASE = 5;

  function automatic logic [ADDR_W-1:0] lo_addr(input int ch);
    return ADDR_LO0 + ADDR_W'(2 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] hi_addr(input int ch);
    return ADDR_LO0 + ADDR_W'(2 * ch + 1);
  endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int PRESCALE = 12,
  parameter int N_EXT    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXT-1:0] ext_pin,
  output logic             tick,
  output logic [N_EXT-1:0] ext_fall
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst)               pcnt <= '0;
    else if (pcnt == LAST) pcnt <= '0;
    else                   pcnt <= pcnt + PW'(1);
  end

  assign tick = (pcnt == LAST);

  for (genvar e = 0; e < N_EXT; e++) begin : g_edge
    logic now_q, old_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        now_q <= 1'b1;
        old_q <= 1'b1;
      end else begin
        now_q <= ext_pin[e];
        old_q <= now_q;
      end
    end
    assign ext_fall[e] = old_q & ~now_q;
  end
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
  import tmr_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b0,
  parameter int BW       = BYTE_W,
  parameter int LW       = M13_LO_W
) (
  input  tmr_mode_e         mode,
  input  logic              step,
  input  logic [BW-1:0]     lo,
  input  logic [BW-1:0]     hi,
  output logic [BW-1:0]     lo_n,
  output logic [BW-1:0]     hi_n,
  output logic              ovf
);
  localparam int W13 = BW + LW;
  localparam int W16 = 2 * BW;

  logic [W13:0] s13;
  logic [W16:0] s16;

  always_comb begin
    lo_n = lo;
    hi_n = hi;
    ovf  = 1'b0;
    s13  = {1'b0, hi, lo[LW-1:0]} + (W13+1)'(1);
    s16  = {1'b0, hi, lo} + (W16+1)'(1);
    if (step) begin
      case (mode)
        MODE_13: begin
          hi_n = s13[W13-1:LW];
          lo_n = {lo[BW-1:LW], s13[LW-1:0]};
          ovf  = s13[W13];
        end
        MODE_16: begin
          {hi_n, lo_n} = s16[W16-1:0];
          ovf          = s16[W16];
        end
        MODE_RELOAD: begin
          if (&lo) begin
            lo_n = hi;
            ovf  = 1'b1;
          end else begin
            lo_n = lo + BW'(1);
          end
        end
        MODE_SPLIT: begin
          if (SPLIT_OK) begin
            lo_n = lo + BW'(1);
            ovf  = &lo;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dual_tmr_cnt.sv
module dual_tmr_cnt
  import tmr_pkg::*;
#(
  parameter int PRESCALE = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [N_CH-1:0]   ext_evt,
  input  logic [N_CH-1:0]   gate_pin,
  input  logic [N_CH-1:0]   flag_ack,
  output logic [N_CH-1:0]   ovf_flag
);
  localparam int NIB = 4;

  logic [BYTE_W-1:0] mode_q;
  logic [N_CH-1:0]   run_q, flag_q, raise, step;
  logic [BYTE_W-1:0] lo_all [N_CH];
  logic [BYTE_W-1:0] hi_all [N_CH];
  chan_cfg_t         cfg    [N_CH];
  logic              tick;
  logic [N_CH-1:0]   ext_fall;
  logic              wr_ctl, wr_mode;
  logic              split_on, split_step, split_ovf;
  logic [BYTE_W-1:0] split_hi_n;
  logic [BYTE_W-1:0] ctl_view;

  assign wr_ctl  = reg_we && (reg_addr == ADDR_CTRL);
  assign wr_mode = reg_we && (reg_addr == ADDR_MODE);

  tmr_tick_gen #(.PRESCALE(PRESCALE), .N_EXT(N_CH)) u_tick (
    .clk(clk), .rst(rst), .ext_pin(ext_evt), .tick(tick), .ext_fall(ext_fall)
  );

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (wr_mode) mode_q <= reg_wdata;
  end

  // channel 0 split mode: high byte runs on the divided clock under run 1
  assign split_on   = (cfg[0].mode == MODE_SPLIT);
  assign split_step = split_on & run_q[1] & tick;
  assign split_ovf  = split_step & (&hi_all[0]);
  assign split_hi_n = split_step ? hi_all[0] + BYTE_W'(1) : hi_all[0];

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [BYTE_W-1:0] lo_r, hi_r, lo_n, hi_n, hi_src;
    logic              u_ovf, run_r, flag_r, flag_n;
    logic              wr_lo, wr_hi;

    assign cfg[g]  = chan_cfg_t'(mode_q[NIB*g +: NIB]);
    assign step[g] = run_r & (~cfg[g].gate | gate_pin[g]) &
                     (cfg[g].ext_src ? ext_fall[g] : tick);
    assign wr_lo   = reg_we && (reg_addr == lo_addr(g));
    assign wr_hi   = reg_we && (reg_addr == hi_addr(g));

    tmr_count_unit #(.SPLIT_OK(g == 0)) u_cnt (
      .mode(cfg[g].mode), .step(step[g]), .lo(lo_r), .hi(hi_r),
      .lo_n(lo_n), .hi_n(hi_n), .ovf(u_ovf)
    );

    if (g == 0) begin : g_hi0
      assign hi_src   = split_on ? split_hi_n : hi_n;
      assign raise[g] = u_ovf;
    end else begin : g_hin
      assign hi_src   = hi_n;
      assign raise[g] = split_on ? split_ovf : u_ovf;
    end

    always_comb begin
      flag_n = flag_r;
      if (wr_ctl)      flag_n = reg_wdata[CTL_FLAG_BASE + 2*g];
      if (flag_ack[g]) flag_n = 1'b0;
      if (raise[g])    flag_n = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_r   <= '0;
        hi_r   <= '0;
        run_r  <= 1'b0;
        flag_r <= 1'b0;
      end else begin
        lo_r   <= wr_lo ? reg_wdata : lo_n;
        hi_r   <= wr_hi ? reg_wdata : hi_src;
        flag_r <= flag_n;
        if (wr_ctl) run_r <= reg_wdata[CTL_RUN_BASE + 2*g];
      end
    end

    assign lo_all[g] = lo_r;
    assign hi_all[g] = hi_r;
    assign run_q[g]  = run_r;
    assign flag_q[g] = flag_r;
  end

  always_comb begin
    ctl_view = '0;
    for (int c = 0; c < N_CH; c++) begin
      ctl_view[CTL_RUN_BASE + 2*c]  = run_q[c];
      ctl_view[CTL_FLAG_BASE + 2*c] = flag_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        3'd0:    reg_rdata <= mode_q;
        3'd1:    reg_rdata <= ctl_view;
        3'd2:    reg_rdata <= lo_all[0];
        3'd3:    reg_rdata <= hi_all[0];
        3'd4:    reg_rdata <= lo_all[1];
        3'd5:    reg_rdata <= hi_all[1];
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign ovf_flag = flag_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [BYTE_W-1:0] mode_reg,
  input logic [N_CH-1:0]   run,
  input logic [N_CH-1:0]   gate_pin,
  input logic [N_CH-1:0]   flag_ack,
  input logic [N_CH-1:0]   raise,
  input logic [N_CH-1:0]   flag,
  input logic [BYTE_W-1:0] lo0,
  input logic [BYTE_W-1:0] hi0,
  input logic [BYTE_W-1:0] lo1,
  input logic [BYTE_W-1:0] hi1
);
  logic wr_lo0, wr_lo1, wr_hi1;
  assign wr_lo0 = reg_we && (reg_addr == 3'd2);
  assign wr_lo1 = reg_we && (reg_addr == 3'd4);
  assign wr_hi1 = reg_we && (reg_addr == 3'd5);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flag == '0 && lo0 == '0 && hi0 == '0 && lo1 == '0 && hi1 == '0));

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
    ((!run[0] || (mode_reg[3] && !gate_pin[0])) && !wr_lo0) |=> $stable(lo0));

  a_r10_ch1_split_holds: assert property (@(posedge clk) disable iff (rst)
    ((mode_reg[5:4] == 2'd3) && !wr_lo1 && !wr_hi1) |=> ($stable(lo1) && $stable(hi1)));

  a_r11_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (flag_ack[0] && !raise[0]) |=> !flag[0]);

  a_r11_overflow_sets: assert property (@(posedge clk) disable iff (rst)
    raise[1] |=> flag[1]);
endmodule

bind dual_tmr_cnt tmr_checker u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .mode_reg(mode_q), .run(run_q), .gate_pin(gate_pin), .flag_ack(flag_ack),
  .raise(raise), .flag(flag_q),
  .lo0(lo_all[0]), .hi0(hi_all[0]), .lo1(lo_all[1]), .hi1(hi_all[1])
);

// File: tb/sim_dual_tmr_cnt.sv
module sim_dual_tmr_cnt;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] ext = 2'b11;
  logic [1:0] gpin = 2'b00;
  logic [1:0] ack = 2'b00;
  logic [1:0] flag;
  logic [1:0] seen = 2'b00;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_tmr_cnt u0 (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .ext_evt(ext), .gate_pin(gpin), .flag_ack(ack),
    .ovf_flag(flag)
  );

  always @(posedge clk) begin
    #1 seen = seen | flag;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic pulse(input int ch);
    ext[ch] = 1'b0; idle(2);
    ext[ch] = 1'b1; idle(2);
  endtask

  function automatic logic [16:0] model(input logic [1:0] m, input logic [7:0] lo_i,
                                        input logic [7:0] hi_i, input int n);
    logic f; logic [7:0] lo; logic [7:0] hi; logic [13:0] t; logic [16:0] s;
    f = 1'b0; lo = lo_i; hi = hi_i;
    for (int i = 0; i < n; i++) begin
      case (m)
        2'd0: begin
          t = {1'b0, hi, lo[4:0]} + 14'd1;
          hi = t[12:5]; lo = {lo[7:5], t[4:0]};
          if (t[13]) f = 1'b1;
        end
        2'd1: begin
          s = {1'b0, hi, lo} + 17'd1;
          {hi, lo} = s[15:0];
          if (s[16]) f = 1'b1;
        end
        default: begin
          if (lo == 8'hFF) begin lo = hi; f = 1'b1; end
          else lo = lo + 8'd1;
        end
      endcase
    end
    return {f, hi, lo};
  endfunction

  task automatic run_events(input string req, input int ch, input logic [1:0] m,
                            input logic [7:0] lo, input logic [7:0] hi, input int n);
    logic [7:0] rl, rh; logic [16:0] e; logic [2:0] la;
    la = (ch == 0) ? 3'd2 : 3'd4;
    wr(3'd1, 8'h00);
    wr(3'd0, (ch == 0) ? {4'h0, 2'b01, m} : {2'b01, m, 4'h0});
    wr(la, lo);
    wr(la + 3'd1, hi);
    seen = 2'b00;
    wr(3'd1, (ch == 0) ? 8'h10 : 8'h40);
    for (int i = 0; i < n; i++) pulse(ch);
    idle(3);
    wr(3'd1, 8'h00);
    rd(la, rl);
    rd(la + 3'd1, rh);
    e = model(m, lo, hi, n);
    chk({req, " low"}, rl, e[7:0]);
    chk({req, " high"}, rh, e[15:8]);
    chk({req, " flag"}, seen[ch], e[16]);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [31:0] r;
    r = $urandom(32'd1234);
    idle(10);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", d, 8'h00);
    end
    chk("R1 reset flags", flag, 2'b00);

    // R2 / R11: register map and readback
    wr(3'd2, 8'hA5); wr(3'd3, 8'h3C); wr(3'd4, 8'h5A); wr(3'd5, 8'hC3);
    wr(3'd0, 8'h96);
    rd(3'd2, d); chk("R2 ch0 low", d, 8'hA5);
    rd(3'd3, d); chk("R2 ch0 high", d, 8'h3C);
    rd(3'd4, d); chk("R2 ch1 low", d, 8'h5A);
    rd(3'd5, d); chk("R2 ch1 high", d, 8'hC3);
    rd(3'd0, d); chk("R2 mode", d, 8'h96);
    wr(3'd1, 8'h0F);
    rd(3'd1, d); chk("R2 control low bits read zero", d, 8'h00);
    rd(3'd6, d); chk("R2 unused address", d, 8'h00);

    // R3: timer source, 60-cycle window gives 5 steps
    wr(3'd0, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd1, 8'h10);
    idle(59);
    wr(3'd1, 8'h00);
    rd(3'd2, d); chk("R3 divided clock count", d, 8'd5);

    // R4: held low counts once
    wr(3'd0, 8'h05); wr(3'd2, 8'h00);
    wr(3'd1, 8'h10);
    ext[0] = 1'b0; idle(20); ext[0] = 1'b1; idle(20);
    wr(3'd1, 8'h00);
    rd(3'd2, d); chk("R4 held level counts once", d, 8'd1);

    // R5: gate low blocks, gate high allows, run off blocks
    wr(3'd0, 8'h0D); wr(3'd2, 8'h00); gpin[0] = 1'b0;
    wr(3'd1, 8'h10);
    pulse(0); pulse(0); pulse(0);
    rd(3'd2, d); chk("R5 gate pin low holds", d, 8'd0);
    gpin[0] = 1'b1;
    pulse(0); pulse(0); idle(3);
    rd(3'd2, d); chk("R5 gate pin high counts", d, 8'd2);
    wr(3'd1, 8'h00);
    pulse(0); pulse(0); idle(3);
    rd(3'd2, d); chk("R5 run off holds", d, 8'd2);
    gpin[0] = 1'b0;

    // R6, R7, R8 directed wrap cases
    run_events("R6 13-bit wrap", 0, 2'd0, 8'hFE, 8'hFF, 2);
    run_events("R7 16-bit wrap", 1, 2'd1, 8'hFF, 8'hFF, 1);
    run_events("R8 reload wrap", 0, 2'd2, 8'hFE, 8'h40, 3);

    // random mix against the model
    for (int k = 0; k < 8; k++) begin
      int ch, n; logic [1:0] m; logic [7:0] lo, hi;
      ch = $urandom % 2;
      m  = 2'($urandom % 3);
      lo = 8'($urandom);
      if ($urandom % 2) lo = lo | 8'hF8;
      hi = 8'($urandom);
      if (m != 2'd2 && ($urandom % 2)) hi = 8'hFF;
      n  = 1 + ($urandom % 5);
      run_events(m == 2'd0 ? "R6 random" : (m == 2'd1 ? "R7 random" : "R8 random"),
                 ch, m, lo, hi, n);
    end

    // R9: split mode on channel 0
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h17); wr(3'd2, 8'hFF); wr(3'd3, 8'hFE);
    seen = 2'b00;
    wr(3'd1, 8'h50);
    pulse(0);
    idle(19);
    wr(3'd1, 8'h00);
    rd(3'd2, d); chk("R9 split low wraps", d, 8'h00);
    rd(3'd3, d); chk("R9 split high two steps", d, 8'h00);
    chk("R9 split flags", seen, 2'b11);

    // R10: channel 1 counts but cannot raise flag 1 during split
    wr(3'd0, 8'h57); wr(3'd3, 8'h00); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    seen = 2'b00;
    wr(3'd1, 8'h40);
    pulse(1); idle(3);
    wr(3'd1, 8'h00);
    rd(3'd4, d); chk("R10 ch1 wraps low", d, 8'h00);
    rd(3'd5, d); chk("R10 ch1 wraps high", d, 8'h00);
    chk("R10 ch1 overflow does not set flag", seen[1], 1'b0);

    // R10: channel 1 in mode 3 holds
    wr(3'd0, 8'h31); wr(3'd4, 8'h12); wr(3'd5, 8'h34);
    wr(3'd1, 8'h40);
    idle(48); pulse(1);
    wr(3'd1, 8'h00);
    rd(3'd4, d); chk("R10 ch1 mode 3 low holds", d, 8'h12);
    rd(3'd5, d); chk("R10 ch1 mode 3 high holds", d, 8'h34);

    // R11: flag clear by ack, by write, and software set
    wr(3'd0, 8'h05); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd1, 8'h10);
    pulse(0); idle(2);
    chk("R11 overflow sets flag", flag[0], 1'b1);
    ack[0] = 1'b1; idle(1); ack[0] = 1'b0; idle(1);
    chk("R11 ack clears flag", flag[0], 1'b0);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    pulse(0); idle(2);
    chk("R11 second overflow", flag[0], 1'b1);
    wr(3'd1, 8'h10); idle(1);
    chk("R11 write zero clears flag", flag[0], 1'b0);
    wr(3'd1, 8'h20); idle(1);
    chk("R11 write one sets flag", flag, 2'b01);
    rd(3'd1, d); chk("R11 control readback", d, 8'h20);
    wr(3'd1, 8'h00);

    finish_run();
  end
endmodule